// File: doc/BRIEF.md
# Ring Product-Term Allocator

This block forms the summed logic input of every cell in a programmable sum-of-products fabric. Each cell brings eight product terms, split into a lower group and an upper group of four terms each. A lend bit for each group decides where that group goes. When the bit is clear, the group stays with its owner. When it is set, the lower group moves to the owner's previous neighbour and the upper group moves to the owner's next neighbour. A cell can therefore OR together as many as sixteen terms: its two own groups, one group received from the next cell and one group received from the previous cell.

The cells are split into rings of equal size. Adjacency wraps around inside each ring, and no term ever crosses from one ring to another. The block is purely combinational. Product-term generation, the cell registers and the output stage sit elsewhere in the fabric.

Top module: `ptalloc_fabric`

## Requirements
- R1: A group whose lend bit is 0 reaches only its owner's sum. Any active term in such a group drives the owner's output to 1.
- R2: When a cell's lower lend bit (`lend_lo[c]`) is 1, its lower group (`pt_lo[4c+3:4c]`) feeds the sum of the previous cell in the same ring.
- R3: When a cell's upper lend bit (`lend_hi[c]`) is 1, its upper group (`pt_hi[4c+3:4c]`) feeds the sum of the next cell in the same ring.
- R4: A lent group is removed from its owner's sum, so each term drives exactly one OR.
- R5: Adjacency wraps around. The previous cell of ring position 0 is the last position of the same ring, and the next cell of the last position is position 0.
- R6: Cell c belongs to ring c / RING_CELLS. No term influences a cell in another ring.
- R7: With every product term at 0, every cell sum is 0, whatever the lend bits.
- R8: Each cell sum is the OR of its kept groups together with the groups lent to it, which is up to sixteen terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pt_lo | input | 4*RING_CELLS*NUM_RINGS | Lower group of four terms for each cell; cell c uses bits [4c+3:4c] |
| pt_hi | input | 4*RING_CELLS*NUM_RINGS | Upper group of four terms for each cell; cell c uses bits [4c+3:4c] |
| lend_lo | input | RING_CELLS*NUM_RINGS | 1 lends cell c's lower group to its previous neighbour |
| lend_hi | input | RING_CELLS*NUM_RINGS | 1 lends cell c's upper group to its next neighbour |
| cell_sum | output | RING_CELLS*NUM_RINGS | Summed logic input of each cell |

## Verification
The bench uses two rings of three cells each and walks through all 4096 lend configurations. For each configuration it applies an all-zero term pattern, which exposes any output that is stuck high (R7). It then activates a single term in one group at a time. Because only one term is active, exactly one cell may go high, so a wrong routing direction, a missing wrap, a group that is not removed from its owner, or a leak into the other ring each show up at a distinct cell. An all-ones pattern and random term patterns then compare the full sixteen-term OR against a model built from the ring arithmetic.

// File: rtl/ptalloc_pkg.sv
package ptalloc_pkg;

    localparam int GROUP_TERMS = 4;

    typedef enum logic {
        GRP_KEEP = 1'b0,
        GRP_LEND = 1'b1
    } grp_route_e;

    typedef struct packed {
        logic kept;
        logic lent;
    } grp_hit_t;

    function automatic int ring_prev(input int pos, input int cells);
        return (pos == 0) ? cells - 1 : pos - 1;
    endfunction

    function automatic int ring_next(input int pos, input int cells);
        return (pos == cells - 1) ? 0 : pos + 1;
    endfunction

endpackage

// File: rtl/ptalloc_group_gate.sv
module ptalloc_group_gate
    import ptalloc_pkg::*;
#(
    parameter int W = GROUP_TERMS
) (
    input  logic [W-1:0] terms,
    input  logic         route,
    output grp_hit_t     hit
);
    grp_route_e route_e;
    logic       any_term;

    always_comb begin
        route_e  = grp_route_e'(route);
        any_term = |terms;
        hit.kept = any_term && (route_e == GRP_KEEP);
        hit.lent = any_term && (route_e == GRP_LEND);
    end

    // R4: a group is never counted on both sides at once
    always_comb begin
        a_r4_single_dest: assert (!(hit.kept && hit.lent));
    end
endmodule

// File: rtl/ptalloc_ring.sv
module ptalloc_ring
    import ptalloc_pkg::*;
#(
    parameter int CELLS = 6,
    parameter int W     = GROUP_TERMS
) (
    input  logic [CELLS*W-1:0] grp_lo,
    input  logic [CELLS*W-1:0] grp_hi,
    input  logic [CELLS-1:0]   lend_lo,
    input  logic [CELLS-1:0]   lend_hi,
    output logic [CELLS-1:0]   sum
);
    grp_hit_t lo_hit [CELLS];
    grp_hit_t hi_hit [CELLS];

    for (genvar g = 0; g < CELLS; g++) begin : g_gate
        ptalloc_group_gate #(.W(W)) u_lo (
            .terms (grp_lo[g*W +: W]),
            .route (lend_lo[g]),
            .hit   (lo_hit[g])
        );
        ptalloc_group_gate #(.W(W)) u_hi (
            .terms (grp_hi[g*W +: W]),
            .route (lend_hi[g]),
            .hit   (hi_hit[g])
        );
    end

    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        localparam int PV = ring_prev(c, CELLS);
        localparam int NX = ring_next(c, CELLS);

        // Own kept groups, lower group lent back from next, upper lent on from previous
        assign sum[c] = lo_hit[c].kept | hi_hit[c].kept
                      | lo_hit[NX].lent | hi_hit[PV].lent;

        always_comb begin
            if (!lend_lo[c] && (|grp_lo[c*W +: W]))
                a_r1_keep_lo: assert (sum[c]);
            if (!lend_hi[c] && (|grp_hi[c*W +: W]))
                a_r1_keep_hi: assert (sum[c]);
            // R2 / R5: lower group lands on the previous cell, wrapping at position 0
            if (lend_lo[c] && (|grp_lo[c*W +: W]))
                a_r2_lend_prev: assert (sum[PV]);
            // R3 / R5: upper group lands on the next cell, wrapping at the last position
            if (lend_hi[c] && (|grp_hi[c*W +: W]))
                a_r3_lend_next: assert (sum[NX]);
            // R4: a cell that lends both groups and receives nothing stays low
            if (lend_lo[c] && lend_hi[c]
                && !(lend_lo[NX] && (|grp_lo[NX*W +: W]))
                && !(lend_hi[PV] && (|grp_hi[PV*W +: W])))
                a_r4_lent_removed: assert (!sum[c]);
        end
    end
endmodule

// File: rtl/ptalloc_fabric.sv
module ptalloc_fabric
    import ptalloc_pkg::*;
#(
    parameter int RING_CELLS = 6,
    parameter int NUM_RINGS  = 2
) (
    input  logic [GROUP_TERMS*RING_CELLS*NUM_RINGS-1:0] pt_lo,
    input  logic [GROUP_TERMS*RING_CELLS*NUM_RINGS-1:0] pt_hi,
    input  logic [RING_CELLS*NUM_RINGS-1:0]             lend_lo,
    input  logic [RING_CELLS*NUM_RINGS-1:0]             lend_hi,
    output logic [RING_CELLS*NUM_RINGS-1:0]             cell_sum
);
    localparam int RING_TERMS = GROUP_TERMS * RING_CELLS;

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
        logic [RING_TERMS-1:0] r_lo;
        logic [RING_TERMS-1:0] r_hi;
        logic [RING_CELLS-1:0] r_sum;

        assign r_lo = pt_lo[r*RING_TERMS +: RING_TERMS];
        assign r_hi = pt_hi[r*RING_TERMS +: RING_TERMS];

        ptalloc_ring #(.CELLS(RING_CELLS), .W(GROUP_TERMS)) u_ring (
            .grp_lo  (r_lo),
            .grp_hi  (r_hi),
            .lend_lo (lend_lo[r*RING_CELLS +: RING_CELLS]),
            .lend_hi (lend_hi[r*RING_CELLS +: RING_CELLS]),
            .sum     (r_sum)
        );

        assign cell_sum[r*RING_CELLS +: RING_CELLS] = r_sum;

        // R6: a ring with no active terms stays silent, whatever the other rings carry
        always_comb begin
            if (!(|r_lo) && !(|r_hi))
                a_r6_ring_isolated: assert (r_sum == '0);
        end
    end

    // R7: no active term anywhere means no active sum
    always_comb begin
        if (!(|pt_lo) && !(|pt_hi))
            a_r7_idle_zero: assert (cell_sum == '0);
    end
endmodule

// File: tb/tb_ptalloc_fabric.sv
module tb_ptalloc_fabric;
    localparam int RC = 3;
    localparam int NR = 2;
    localparam int NC = RC * NR;
    localparam int NT = 4 * NC;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [NT-1:0] pt_lo, pt_hi;
    logic [NC-1:0] lend_lo, lend_hi, cell_sum;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    ptalloc_fabric #(.RING_CELLS(RC), .NUM_RINGS(NR)) dut (
        .pt_lo(pt_lo), .pt_hi(pt_hi), .lend_lo(lend_lo), .lend_hi(lend_hi),
        .cell_sum(cell_sum)
    );

    function automatic logic [NC-1:0] model();
        logic [NC-1:0] e = '0;
        for (int c = 0; c < NC; c++) begin
            int base = (c / RC) * RC;
            int p    = c % RC;
            int nx   = base + (p + 1) % RC;
            int pv   = base + (p + RC - 1) % RC;
            e[c] = (!lend_lo[c] && (|pt_lo[4*c +: 4]))
                 | (!lend_hi[c] && (|pt_hi[4*c +: 4]))
                 | (lend_lo[nx] && (|pt_lo[4*nx +: 4]))
                 | (lend_hi[pv] && (|pt_hi[4*pv +: 4]));
        end
        return e;
    endfunction

    task automatic check_all(input string req);
        logic [NC-1:0] exp_v;
        #2;
        exp_v = model();
        for (int c = 0; c < NC; c++) begin
            checks++;
            if (cell_sum[c] !== exp_v[c]) begin
                errors++;
                if (errors < 20)
                    $display("FAIL %s cell %0d got %b exp %b (lo=%b hi=%b)",
                             req, c, cell_sum[c], exp_v[c], lend_lo, lend_hi);
            end
        end
    endtask

    // Single active term in group g; each cell tagged by the rule it tests
    task automatic check_single(input int g);
        int owner = (g < NC) ? g : g - NC;
        bit is_lo = (g < NC);
        int ring  = owner / RC;
        int p     = owner % RC;
        int dest;
        bool_t: begin end
        pt_lo = '0; pt_hi = '0;
        if (is_lo) pt_lo[4*owner + (g % 4)] = 1'b1;
        else       pt_hi[4*owner + (g % 4)] = 1'b1;
        if (is_lo && lend_lo[owner])       dest = ring*RC + (p + RC - 1) % RC;
        else if (!is_lo && lend_hi[owner]) dest = ring*RC + (p + 1) % RC;
        else                               dest = owner;
        #2;
        for (int c = 0; c < NC; c++) begin
            logic exp_b = (c == dest);
            string req;
            if (c == dest) begin
                if (dest == owner) req = "R1";
                else if ((is_lo && p == 0) || (!is_lo && p == RC-1)) req = "R5";
                else req = is_lo ? "R2" : "R3";
            end else if (c / RC != ring) req = "R6";
            else req = "R4";
            checks++;
            if (cell_sum[c] !== exp_b) begin
                errors++;
                if (errors < 20)
                    $display("FAIL %s cell %0d got %b exp %b (group %0d lo=%b hi=%b)",
                             req, c, cell_sum[c], exp_b, g, lend_lo, lend_hi);
            end
        end
    endtask

    initial begin
        pt_lo = '0; pt_hi = '0; lend_lo = '0; lend_hi = '0;
        #3;
        check_all("R7");
        for (int cfg = 0; cfg < (1 << (2*NC)); cfg++) begin
            lend_lo = cfg[NC-1:0];
            lend_hi = cfg[2*NC-1:NC];
            pt_lo = '0; pt_hi = '0;
            check_all("R7");
            for (int g = 0; g < 2*NC; g++) check_single(g);
            pt_lo = '1; pt_hi = '1;
            check_all("R8");
            pt_lo = NT'($urandom); pt_hi = NT'($urandom);
            check_all("R8");
        end
        for (int k = 0; k < 200; k++) begin
            lend_lo = NC'($urandom); lend_hi = NC'($urandom);
            pt_lo = NT'($urandom) & NT'($urandom);
            pt_hi = NT'($urandom) & NT'($urandom);
            check_all("R8");
        end
        done = 1'b1;
    end

    initial begin
        for (int cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout exp completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule